// File: doc/BRIEF.md
# HDLC Receive Deframer

This block recovers frames from a bit-serial HDLC line. Each bit arrives with a one-cycle enable. The block searches the line for the 0x7E flag. Inside a frame it removes the zero that the transmitter inserts after five ones, and it packs the remaining bits into octets, least significant bit first. Every octet leaves on a byte-wide output with a valid strobe. A marker flags the first octet of each frame. The frame check sequence bytes leave on the same path as data.

At the end of a frame the block emits one status word. The word carries three error flags (abort, non-octet, CRC error) and the number of valid bits in the final octet. A mode input selects a 16-bit or a 32-bit CCITT check. The CRC engine always runs. A consumer that does not need the check can ignore its result.

The priority at frame end is fixed:
- An abort overrides both the length check and the CRC check.
- A frame that ends off an octet boundary never reports a CRC error.
- Every error returns the receiver to flag search.
- A closing flag also opens the next frame, so a back-to-back frame that follows an error is captured.

Two counters, one for aborts and one for CRC errors, saturate at their maximum and clear synchronously.

The octet and status outputs have no ready input. The serial line cannot be stalled, so a beat on either output lasts exactly one cycle and is lost if the consumer is not taking it.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Outside a frame, no octet or status is produced until a 0x7E flag (0 1 1 1 1 1 1 0 on the line) is seen. A flag that closes a frame also opens the next, so flags may be shared between frames. A run of ones ended by a 0 is a flag only when the run is exactly six.
- R2: Inside a frame, a 0 that follows five consecutive 1 bits is discarded and never reaches the octet output.
- R3: Recovered bits are packed LSB first (the first bit received is out_data[0]) and emitted with out_valid for one cycle. out_first is 1 on the first octet of each frame. Flag bits are never emitted. The check-sequence bytes are emitted as ordinary octets.
- R4: The block uses the 16-bit check (x^16+x^12+x^5+1) when crc_sel = 2'b00. The register is preset to all ones. The check passes when the register, fed every frame bit including the check sequence in arrival order, ends at 0x1D0F. A check sequence sent as the complemented register, most significant bit first, therefore passes.
- R5: The block uses the 32-bit check (x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1) when crc_sel = 2'b10. The preset is all ones and the good residue is 0xC704DD7B. The reserved values 2'b01 and 2'b11 behave as 2'b00.
- R6: A reported frame whose destuffed length is a multiple of 8 gives eof_lastbits = 8 and eof_nonoct = 0. Otherwise the k leftover bits are emitted as a final octet in out_data[k-1:0], in the same cycle as the status. That status has eof_nonoct = 1, eof_crcerr = 0 and eof_lastbits = k.
- R7: Seven consecutive 1 bits inside a frame that has already emitted at least one bit end it with eof_abort = 1, eof_nonoct = 0, eof_crcerr = 0 and eof_lastbits = 0. The bits still held back (up to 6) are discarded, and the block searches for a flag again.
- R8: abort_cnt rises by one for each status with eof_abort = 1. crcerr_cnt rises by one for each status with eof_crcerr = 1. Both hold at all ones instead of wrapping. cnt_clr forces both to zero on the next edge and wins over an increment.
- R9: A frame with fewer full octets than the check length plus one octet (3 for 16-bit, 5 for 32-bit) produces no status, no partial octet and no counter change. Its full octets may already have been emitted.
- R10: After an abort, a non-octet frame or a CRC error, the next frame is received normally, including one that shares the closing flag.
- R11: rx_bit is ignored in cycles where rx_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | rx_bit carries a line bit this cycle |
| rx_bit | input | 1 | Serial line bit |
| crc_sel | input | 2 | Check select: 00 16-bit, 10 32-bit, x1 reserved |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| out_valid | output | 1 | An octet is on out_data |
| out_data | output | 8 | Recovered octet, first received bit in bit 0 |
| out_first | output | 1 | Octet is the first of its frame |
| eof_valid | output | 1 | Frame-end status is present |
| eof_abort | output | 1 | Frame ended by an abort |
| eof_nonoct | output | 1 | Frame length not a multiple of 8 |
| eof_crcerr | output | 1 | Check residue mismatch |
| eof_lastbits | output | 4 | Valid bits in the final octet (0 on abort) |
| abort_cnt | output | CNT_W | Saturating abort counter |
| crcerr_cnt | output | CNT_W | Saturating CRC error counter |

## Verification
The bench builds the block with CNT_W = 3. This lets nine CRC-error frames and eight aborted frames drive both counters into saturation at 7, where the hold and the synchronous clear can be observed. It drives both check widths and the reserved select value. Frames open with bytes 0x7E and 0xFF so that stuffing always occurs. Enable gaps carry inverted line bits. Short, non-octet and aborted frames sit back to back with good frames on shared flags.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned OCTET_W  = 8;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned WIDE_W   = 32;
  localparam logic [NARROW_W-1:0] NARROW_POLY = 16'h1021;
  localparam logic [NARROW_W-1:0] NARROW_GOOD = 16'h1D0F;
  localparam logic [WIDE_W-1:0]   WIDE_POLY   = 32'h04C11DB7;
  localparam logic [WIDE_W-1:0]   WIDE_GOOD   = 32'hC704DD7B;

  function automatic logic [NARROW_W-1:0] narrow_step(input logic [NARROW_W-1:0] c, input logic b);
    return {c[NARROW_W-2:0], 1'b0} ^ ((c[NARROW_W-1] ^ b) ? NARROW_POLY : '0);
  endfunction

  function automatic logic [WIDE_W-1:0] wide_step(input logic [WIDE_W-1:0] c, input logic b);
    return {c[WIDE_W-2:0], 1'b0} ^ ((c[WIDE_W-1] ^ b) ? WIDE_POLY : '0);
  endfunction
endpackage

// File: rtl/hdlc_rx_destuff.sv
module hdlc_rx_destuff (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic take,
  output logic flag,
  output logic abort_seq
);
  localparam int RUN_W = 3;
  localparam logic [RUN_W-1:0] STUFF_RUN = 3'd5;
  localparam logic [RUN_W-1:0] FLAG_RUN  = 3'd6;
  localparam logic [RUN_W-1:0] RUN_TOP   = 3'd7;

  logic [RUN_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (!rst_n)   ones <= '0;
    else if (en)  ones <= din ? ((ones == RUN_TOP) ? RUN_TOP : ones + 1'b1) : '0;
  end

  // a bit is payload only while the run of ones is shorter than the stuffing limit
  assign take      = en && (ones < STUFF_RUN);
  assign flag      = en && !din && (ones == FLAG_RUN);
  assign abort_seq = en &&  din && (ones == FLAG_RUN);

  // R2
  stuffed_zero_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !din && ones == STUFF_RUN) |-> (!take && !flag));
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init,
  input  logic                step,
  input  logic                din,
  output logic [NARROW_W-1:0] c_narrow,
  output logic [WIDE_W-1:0]   c_wide
);
  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      c_narrow <= '1;
      c_wide   <= '1;
    end else if (step) begin
      c_narrow <= narrow_step(c_narrow, din);
      c_wide   <= wide_step(c_wide, din);
    end
  end
endmodule

// File: rtl/hdlc_rx_satcnt.sv
module hdlc_rx_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)          cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == TOP) |=> (cnt == TOP));
  // R8
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic [1:0]       crc_sel,
  input  logic             cnt_clr,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             eof_valid,
  output logic             eof_abort,
  output logic             eof_nonoct,
  output logic             eof_crcerr,
  output logic [3:0]       eof_lastbits,
  output logic [CNT_W-1:0] abort_cnt,
  output logic [CNT_W-1:0] crcerr_cnt
);
  // payload bits accepted before a closing flag is recognised (its 0 and five 1s)
  localparam int HOLD   = 6;
  localparam int HC_W   = $clog2(HOLD + 1);
  localparam int BC_W   = $clog2(OCTET_W);
  localparam int NB_W   = 3;
  localparam logic [NB_W-1:0] MIN_NARROW = NB_W'(NARROW_W / OCTET_W + 1);
  localparam logic [NB_W-1:0] MIN_WIDE   = NB_W'(WIDE_W / OCTET_W + 1);
  localparam logic [NB_W-1:0] NB_TOP     = '1;

  logic take, flag, abort_seq;
  logic in_frame, started, first_pend;
  logic [HOLD-1:0]    hold_q;
  logic [HC_W-1:0]    hold_n;
  logic [OCTET_W-1:0] pack_q;
  logic [BC_W-1:0]    bit_n;
  logic [NB_W-1:0]    oct_n;
  logic [NARROW_W-1:0] c_narrow;
  logic [WIDE_W-1:0]   c_wide;

  hdlc_rx_destuff u_destuff (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .din(rx_bit),
    .take(take), .flag(flag), .abort_seq(abort_seq)
  );

  wire accept   = take && in_frame;
  wire release_ = accept && (hold_n == HC_W'(HOLD));
  wire rel_bit  = hold_q[0];
  wire oct_done = release_ && (bit_n == BC_W'(OCTET_W - 1));

  hdlc_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(flag || abort_seq), .step(release_), .din(rel_bit),
    .c_narrow(c_narrow), .c_wide(c_wide)
  );

  wire use_wide  = (crc_sel == 2'b10);
  wire long_enuf = oct_n >= (use_wide ? MIN_WIDE : MIN_NARROW);
  wire partial   = (bit_n != '0);
  wire crc_bad   = use_wide ? (c_wide != WIDE_GOOD) : (c_narrow != NARROW_GOOD);
  wire close_rep = flag && in_frame && started && long_enuf;
  wire abort_rep = abort_seq && in_frame && started;
  wire crc_fail  = close_rep && !partial && crc_bad;

  // frame tracking and octet assembly
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;  started <= 1'b0;  first_pend <= 1'b0;
      hold_q <= '0;  hold_n <= '0;  pack_q <= '0;  bit_n <= '0;  oct_n <= '0;
    end else if (flag || abort_seq) begin
      in_frame   <= flag;
      started    <= 1'b0;
      first_pend <= 1'b1;
      hold_n     <= '0;
      bit_n      <= '0;
      oct_n      <= '0;
    end else if (accept) begin
      hold_q <= {rx_bit, hold_q[HOLD-1:1]};
      if (!release_) hold_n <= hold_n + 1'b1;
      if (release_) begin
        pack_q  <= {rel_bit, pack_q[OCTET_W-1:1]};
        bit_n   <= bit_n + 1'b1;
        started <= 1'b1;
      end
      if (oct_done) begin
        first_pend <= 1'b0;
        if (oct_n != NB_TOP) oct_n <= oct_n + 1'b1;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;  out_data <= '0;  out_first <= 1'b0;
      eof_valid <= 1'b0;  eof_abort <= 1'b0;  eof_nonoct <= 1'b0;
      eof_crcerr <= 1'b0; eof_lastbits <= '0;
    end else begin
      out_valid    <= oct_done || (close_rep && partial);
      out_data     <= oct_done ? {rel_bit, pack_q[OCTET_W-1:1]}
                               : (pack_q >> (4'(OCTET_W) - {1'b0, bit_n}));
      out_first    <= first_pend;
      eof_valid    <= close_rep || abort_rep;
      eof_abort    <= abort_rep;
      eof_nonoct   <= close_rep && partial;
      eof_crcerr   <= crc_fail;
      eof_lastbits <= abort_rep ? 4'd0 : (partial ? {1'b0, bit_n} : 4'(OCTET_W));
    end
  end

  hdlc_rx_satcnt #(.W(CNT_W)) u_abort_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(abort_rep), .cnt(abort_cnt)
  );
  hdlc_rx_satcnt #(.W(CNT_W)) u_crc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(crc_fail), .cnt(crcerr_cnt)
  );

  // R6
  partial_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && eof_valid) |-> eof_nonoct);
  // R7
  abort_masks_checks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_valid && eof_abort) |-> (!eof_nonoct && !eof_crcerr && eof_lastbits == 4'd0));
  // R6
  lastbits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_valid && !eof_abort) |-> (eof_lastbits != 4'd0 && eof_lastbits <= 4'd8));
  // R11
  octet_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || eof_valid) |-> $past(rx_en));
  // R8
  abort_count_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_valid && eof_abort && !$past(cnt_clr) && $past(abort_cnt) != '1) |-> (abort_cnt == $past(abort_cnt) + 1'b1));
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb_top;
  localparam int CW  = 3;
  localparam int TOP = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_bit = 1'b0, cnt_clr = 1'b0;
  logic [1:0] crc_sel = 2'b00;
  logic out_valid, out_first, eof_valid, eof_abort, eof_nonoct, eof_crcerr;
  logic [7:0] out_data;
  logic [3:0] eof_lastbits;
  logic [CW-1:0] abort_cnt, crcerr_cnt;

  always #5 clk = ~clk;

  hdlc_rx_deframer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .crc_sel(crc_sel),
    .cnt_clr(cnt_clr), .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .eof_valid(eof_valid), .eof_abort(eof_abort), .eof_nonoct(eof_nonoct),
    .eof_crcerr(eof_crcerr), .eof_lastbits(eof_lastbits),
    .abort_cnt(abort_cnt), .crcerr_cnt(crcerr_cnt)
  );

  int nchk = 0, nerr = 0;
  int gap_mode = 1;
  int tx_ones = 0;
  int exp_abt = 0, exp_crc = 0;
  bit done = 0;
  logic [8:0] exp_b[$];
  logic [6:0] exp_s[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] crc_adv(input bit [31:0] c, input bit b, input bit wide);
    bit fb;
    if (wide) begin
      fb = c[31] ^ b; c = {c[30:0], 1'b0};
      if (fb) c ^= 32'h04C11DB7;
    end else begin
      fb = c[15] ^ b; c[15:0] = {c[14:0], 1'b0};
      if (fb) c[15:0] ^= 16'h1021;
    end
    return c;
  endfunction

  // R11: gap cycles carry the inverted bit with the enable low
  task automatic send_raw(input bit b);
    @(negedge clk); rx_en = 1'b1; rx_bit = b;
    if (gap_mode == 2 || (gap_mode == 1 && ($urandom % 2) == 1)) begin
      @(negedge clk); rx_en = 1'b0; rx_bit = ~b;
    end
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    tx_ones = 0;
  endtask

  // R2: transmitter inserts a zero after five ones
  task automatic send_stuffed(input bit b);
    send_raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic push_bytes(input bit q[$], input int nfull);
    for (int f = 0; f < nfull; f++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = q[8*f+j];
      exp_b.push_back({f == 0, v});
    end
  endtask

  task automatic body(input int nbytes, input int k, input bit corrupt, input bit wide);
    bit q[$];
    bit [31:0] c = '1;
    int w = wide ? 32 : 16;
    int tot, nfull;
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] v = (i == 0) ? 8'h7E : (i == 1) ? 8'hFF : 8'($urandom);
      for (int j = 0; j < 8; j++) q.push_back(v[j]);
    end
    for (int j = 0; j < k; j++) q.push_back(1'($urandom));
    foreach (q[i]) c = crc_adv(c, q[i], wide);
    for (int j = 0; j < w; j++) q.push_back(~c[w-1-j] ^ (corrupt && j == 3));
    tot = q.size();
    nfull = tot / 8;
    push_bytes(q, nfull);
    if (nfull >= w / 8 + 1) begin
      if (k != 0) begin
        logic [7:0] v = '0;
        for (int j = 0; j < k; j++) v[j] = q[8*nfull+j];
        exp_b.push_back({nfull == 0, v});
        exp_s.push_back({1'b0, 1'b1, 1'b0, 4'(k)});
      end else begin
        exp_s.push_back({1'b0, 1'b0, corrupt, 4'd8});
        if (corrupt && exp_crc < TOP) exp_crc++;
      end
    end
    foreach (q[i]) send_stuffed(q[i]);
  endtask

  // R7: data then seven raw ones; the last six accepted bits are never released
  task automatic abort_body(input int nbytes);
    bit q[$];
    int m = tx_ones, rel;
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] v = (i == 0) ? 8'hFF : 8'($urandom);
      for (int j = 0; j < 8; j++) q.push_back(v[j]);
    end
    foreach (q[i]) begin
      if (q[i]) begin m++; if (m == 5) m = 0; end else m = 0;
    end
    rel = q.size() - 1 - m;
    if (rel >= 1) begin
      push_bytes(q, rel / 8);
      exp_s.push_back({1'b1, 1'b0, 1'b0, 4'd0});
      if (exp_abt < TOP) exp_abt++;
    end
    foreach (q[i]) send_stuffed(q[i]);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
  endtask

  task automatic settle(input string tag);
    @(negedge clk); rx_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(exp_b.size() == 0 && exp_s.size() == 0, tag, exp_b.size() + exp_s.size(), 0);
    chk(abort_cnt == CW'(exp_abt), "R8 abort_cnt", abort_cnt, exp_abt);
    chk(crcerr_cnt == CW'(exp_crc), "R8 crcerr_cnt", crcerr_cnt, exp_crc);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin : mon
    logic [8:0] eb;
    logic [6:0] es;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_b.size() == 0) chk(1'b0, "R3 unexpected octet", out_data, 0);
        else begin
          eb = exp_b.pop_front();
          chk({out_first, out_data} == eb, "R3 octet/first", {out_first, out_data}, eb);
        end
      end
      if (eof_valid) begin
        if (exp_s.size() == 0) chk(1'b0, "R9 unexpected status", eof_lastbits, 0);
        else begin
          es = exp_s.pop_front();
          chk({eof_abort, eof_nonoct, eof_crcerr, eof_lastbits} == es, "R4/R5/R6/R7 status",
              {eof_abort, eof_nonoct, eof_crcerr, eof_lastbits}, es);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !eof_valid, "R1 reset outputs", {out_valid, eof_valid}, 0);
    chk(abort_cnt == 0 && crcerr_cnt == 0, "R8 reset counters", {abort_cnt, crcerr_cnt}, 0);

    // R1: line noise without a flag (runs of 7+ and of 1..2 ones) yields nothing
    for (int i = 0; i < 12; i++) send_raw(1'b1);
    send_raw(1'b0); send_raw(1'b0); send_raw(1'b1); send_raw(1'b0); send_raw(1'b1); send_raw(1'b1);
    settle("R1 hunt quiet");

    // R2 R3 R4: good 16-bit frame with stuffing-heavy bytes
    send_flag(); body(4, 0, 0, 0); send_flag();
    settle("R4 good narrow frame");

    // R5 R10: wide check, good / corrupt / good on shared flags
    crc_sel = 2'b10;
    send_flag(); body(6, 0, 0, 1); send_flag(); body(5, 0, 1, 1); send_flag();
    body(4, 0, 0, 1); send_flag();
    settle("R5 R10 wide frames");
    crc_sel = 2'b01;
    send_flag(); body(3, 0, 0, 0); send_flag();
    settle("R5 reserved select");
    crc_sel = 2'b00;

    // R6 R10: non-octet frame then back-to-back good frame
    send_flag(); body(4, 3, 0, 0); send_flag(); body(2, 0, 0, 0); send_flag();
    settle("R6 R10 non-octet");

    // R7 R10: abort then a clean frame
    send_flag(); abort_body(3); send_flag(); body(3, 0, 0, 0); send_flag();
    settle("R7 R10 abort");

    // R9: short frames, with and without a leftover, leave no status
    send_flag(); body(0, 0, 0, 0); send_flag(); body(0, 3, 0, 0); send_flag();
    settle("R9 short frames");

    // R11: every bit followed by a disabled cycle with the opposite value
    gap_mode = 2;
    send_flag(); body(5, 0, 0, 0); send_flag();
    settle("R11 enable gaps");
    gap_mode = 0;
    send_flag(); body(3, 0, 1, 0); send_flag();
    settle("R11 dense enables");
    gap_mode = 1;

    // R8: saturation of both counters
    send_flag();
    for (int i = 0; i < 9; i++) begin body(3, 0, 1, 0); send_flag(); end
    for (int i = 0; i < 8; i++) begin abort_body(2); send_flag(); end
    settle("R8 saturation");
    chk(crcerr_cnt == CW'(TOP) && abort_cnt == CW'(TOP), "R8 saturated at top",
        {abort_cnt, crcerr_cnt}, {CW'(TOP), CW'(TOP)});

    // R8: synchronous clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    exp_abt = 0; exp_crc = 0;
    chk(abort_cnt == 0 && crcerr_cnt == 0, "R8 clear", {abort_cnt, crcerr_cnt}, 0);
    send_flag(); body(3, 0, 1, 0); send_flag();
    settle("R8 count after clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule